// File: doc/BRIEF.md
# Jump Condition and Target Resolver

This block resolves the jump-format instructions of a small 8-bit processor. Each accepted request carries a 4-bit jump code, an 8-bit operand, the four condition flags (zero, negative, overflow, carry) and the current program counter. One clock later the block reports whether control transfers, the next program counter, and, for the procedure codes, which stack sequence the control unit has to run and how the stack pointer must be adjusted.

The code space holds three groups. Signed tests compare the negative and overflow flags, with or without the zero flag. Unsigned tests use the carry flag, with or without the zero flag. Procedure operations are call, enter, leave and return. For enter, leave and return the operand is a byte count for the stack pointer and is not a target address. For leave, the control unit copies y into the stack pointer, pops y, pops the program counter and only then applies the count. The block reports only the direction and the amount; the memory traffic belongs to the control unit.

Top module: `jump_resolver`

## Requirements
- R1: After reset, all outputs are 0 until the first accepted request.
- R2: A request with `req_valid` high at a rising edge produces results on the outputs after that edge, with `res_valid` high for exactly that cycle. When `req_valid` is low, `res_valid` is 0 at the next cycle and every other output keeps its value.
- R3: Code 0 is always taken.
- R4: Code 6 is taken when z = 0. Code 7 is taken when z = 1.
- R5: Code 8 is taken when n equals v. Code 9 is taken when n differs from v.
- R6: Code 10 is taken when z = 0 and n equals v. Code 11 is taken when z = 1 or n differs from v.
- R7: Code 12 is taken when c = 0 and code 13 when c = 1. Code 14 is taken when c = 0 and z = 0. Code 15 is taken when c = 1 or z = 1.
- R8: When `taken` is 1, `next_pc` equals the operand. Otherwise `next_pc` equals pc + 2, modulo 256.
- R9: Code 1 (call) is taken, sets `proc_op` bit 0, and requests no stack adjust. `proc_op` is one-hot or zero, with bit 0 = call, bit 1 = enter, bit 2 = leave and bit 3 = return.
- R10: Code 2 (enter) is not taken. It sets `proc_op` bit 1 and requests a subtraction of the operand from the stack pointer (`sp_adj_en` = 1, `sp_adj_sub` = 1, `sp_adj_amt` = operand).
- R11: Code 3 (leave) and code 4 (return) are not taken. They set `proc_op` bit 2 or bit 3 and request an addition of the operand (`sp_adj_en` = 1, `sp_adj_sub` = 0, `sp_adj_amt` = operand).
- R12: Code 5 raises `illegal`. It is not taken, sets no `proc_op` bit and requests no stack adjust.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| jcode | input | 4 | Jump code |
| operand | input | 8 | Target address or byte count |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| pc | input | 8 | Address of the jump instruction |
| res_valid | output | 1 | Result strobe |
| taken | output | 1 | Control transfers to the operand |
| next_pc | output | 8 | Next program counter |
| illegal | output | 1 | Code is reserved |
| proc_op | output | 4 | One-hot procedure sequence request |
| sp_adj_en | output | 1 | Stack pointer adjust requested |
| sp_adj_sub | output | 1 | 1 = subtract, 0 = add |
| sp_adj_amt | output | 8 | Adjust byte count |

## Verification
The assertions check on every cycle that `res_valid` follows each request and that the unconditional and zero-equal codes resolve as required. They also check that a fall-through lands on pc + 2, that `proc_op` never has more than one bit set, that a stack adjust appears only with a stack sequence, and that a reserved code stays quiet. The bench's reference model covers everything else. It sweeps every code against all sixteen flag combinations, places the program counter at the wrap point, and checks that the outputs hold their values during idle cycles. These are properties of whole truth tables and of output retention, and only the scenarios can show them.

// File: rtl/jr_pkg.sv
package jr_pkg;

  typedef enum logic [3:0] {
    JC_ALWAYS = 4'd0,  JC_CALL = 4'd1,  JC_ENTER = 4'd2, JC_LEAVE = 4'd3,
    JC_RET    = 4'd4,  JC_RSVD = 4'd5,  JC_NE    = 4'd6, JC_EQ    = 4'd7,
    JC_GE     = 4'd8,  JC_LT   = 4'd9,  JC_GT    = 4'd10, JC_LE   = 4'd11,
    JC_AE     = 4'd12, JC_B    = 4'd13, JC_A     = 4'd14, JC_BE   = 4'd15
  } jcode_e;

  localparam int PROC_W   = 4;
  localparam int PB_CALL  = 0;
  localparam int PB_ENTER = 1;
  localparam int PB_LEAVE = 2;
  localparam int PB_RET   = 3;

  // Flag test for the conditional group and the unconditional code.
  function automatic logic flag_test(input jcode_e code, input logic z,
                                     input logic n, input logic v, input logic c);
    logic sgn_ge;
    sgn_ge = (n == v);
    case (code)
      JC_ALWAYS: return 1'b1;
      JC_NE:     return !z;
      JC_EQ:     return z;
      JC_GE:     return sgn_ge;
      JC_LT:     return !sgn_ge;
      JC_GT:     return !z && sgn_ge;
      JC_LE:     return z || !sgn_ge;
      JC_AE:     return !c;
      JC_B:      return c;
      JC_A:      return !c && !z;
      JC_BE:     return c || z;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/jr_cond_eval.sv
module jr_cond_eval
  import jr_pkg::*;
(
  input  logic [3:0] code,
  input  logic       z,
  input  logic       n,
  input  logic       v,
  input  logic       c,
  output logic       is_flag_code,
  output logic       cond_true
);
  jcode_e code_e;
  assign code_e = jcode_e'(code);

  always_comb begin
    is_flag_code = (code_e == JC_ALWAYS) || (code >= 4'(JC_NE));
    cond_true    = flag_test(code_e, z, n, v, c);
  end
endmodule

// File: rtl/jr_proc_decode.sv
module jr_proc_decode
  import jr_pkg::*;
(
  input  logic [3:0]        code,
  output logic [PROC_W-1:0] proc_op,
  output logic              rsvd,
  output logic              sp_en,
  output logic              sp_sub
);
  always_comb begin
    proc_op = '0;
    rsvd    = 1'b0;
    sp_en   = 1'b0;
    sp_sub  = 1'b0;
    case (jcode_e'(code))
      JC_CALL:  proc_op[PB_CALL] = 1'b1;
      JC_ENTER: begin proc_op[PB_ENTER] = 1'b1; sp_en = 1'b1; sp_sub = 1'b1; end
      JC_LEAVE: begin proc_op[PB_LEAVE] = 1'b1; sp_en = 1'b1; end
      JC_RET:   begin proc_op[PB_RET]   = 1'b1; sp_en = 1'b1; end
      JC_RSVD:  rsvd = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/jr_target.sv
module jr_target #(
  parameter int AW   = 8,
  parameter int STEP = 2
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] operand,
  input  logic          take,
  output logic [AW-1:0] next_pc
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] a);
    return a + STEP_V;
  endfunction

  assign next_pc = take ? operand : advance(pc);
endmodule

// File: rtl/jump_resolver.sv
module jump_resolver
  import jr_pkg::*;
#(
  parameter int AW   = 8,
  parameter int STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        jcode,
  input  logic [AW-1:0]     operand,
  input  logic              flag_z,
  input  logic              flag_n,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic [AW-1:0]     pc,
  output logic              res_valid,
  output logic              taken,
  output logic [AW-1:0]     next_pc,
  output logic              illegal,
  output logic [PROC_W-1:0] proc_op,
  output logic              sp_adj_en,
  output logic              sp_adj_sub,
  output logic [AW-1:0]     sp_adj_amt
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic              is_flag_code, cond_true;
  logic [PROC_W-1:0] proc_c;
  logic              rsvd_c, sp_en_c, sp_sub_c;
  logic              taken_c;
  logic [AW-1:0]     next_pc_c;

  jr_cond_eval u_cond (
    .code(jcode), .z(flag_z), .n(flag_n), .v(flag_v), .c(flag_c),
    .is_flag_code(is_flag_code), .cond_true(cond_true)
  );

  jr_proc_decode u_proc (
    .code(jcode), .proc_op(proc_c), .rsvd(rsvd_c),
    .sp_en(sp_en_c), .sp_sub(sp_sub_c)
  );

  assign taken_c = (is_flag_code && cond_true) || proc_c[PB_CALL];

  jr_target #(.AW(AW), .STEP(STEP)) u_tgt (
    .pc(pc), .operand(operand), .take(taken_c), .next_pc(next_pc_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      taken      <= 1'b0;
      next_pc    <= '0;
      illegal    <= 1'b0;
      proc_op    <= '0;
      sp_adj_en  <= 1'b0;
      sp_adj_sub <= 1'b0;
      sp_adj_amt <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        taken      <= taken_c;
        next_pc    <= next_pc_c;
        illegal    <= rsvd_c;
        proc_op    <= proc_c;
        sp_adj_en  <= sp_en_c;
        sp_adj_sub <= sp_sub_c;
        sp_adj_amt <= sp_en_c ? operand : '0;
      end
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid); // R2
  AST_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && jcode == 4'd0) |=> (taken && next_pc == $past(operand))); // R3
  AST_EQ_FOLLOWS_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && jcode == 4'd7) |=> (taken == $past(flag_z))); // R4
  AST_FALLTHROUGH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !taken_c) |=> (next_pc == $past(pc) + STEP_V)); // R8
  AST_PROC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(proc_op)); // R9
  AST_SPADJ_NEEDS_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    sp_adj_en |-> (proc_op[PB_ENTER] || proc_op[PB_LEAVE] || proc_op[PB_RET])); // R10
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!taken && proc_op == '0 && !sp_adj_en)); // R12
endmodule

// File: tb/jump_resolver_tb.sv
module jump_resolver_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] jcode = '0;
  logic [7:0] operand = '0;
  logic       flag_z = 0, flag_n = 0, flag_v = 0, flag_c = 0;
  logic [7:0] pc = '0;
  logic       res_valid, taken, illegal, sp_adj_en, sp_adj_sub;
  logic [7:0] next_pc, sp_adj_amt;
  logic [3:0] proc_op;

  int checks = 0, errors = 0;
  logic [24:0] exp_v = '0;
  string exp_tag = "R1";

  always #2.5 clk = ~clk;

  jump_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .jcode(jcode),
    .operand(operand), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
    .flag_c(flag_c), .pc(pc), .res_valid(res_valid), .taken(taken),
    .next_pc(next_pc), .illegal(illegal), .proc_op(proc_op),
    .sp_adj_en(sp_adj_en), .sp_adj_sub(sp_adj_sub), .sp_adj_amt(sp_adj_amt)
  );

  function automatic string tag_of(int code);
    if (code == 0) return "R3";
    if (code == 1) return "R9";
    if (code == 2) return "R10";
    if (code == 3 || code == 4) return "R11";
    if (code == 5) return "R12";
    if (code <= 7) return "R4";
    if (code <= 9) return "R5";
    if (code <= 11) return "R6";
    return "R7";
  endfunction

  // Behavioural reference: truth written from the requirement text.
  function automatic logic [24:0] model(int code, int opd, int p, bit z, bit n, bit v, bit c);
    bit t = 0, ill = 0, en = 0, sub = 0;
    int po = 0, npc, amt = 0;
    if (code == 0) t = 1;
    else if (code == 1) begin t = 1; po = 1; end
    else if (code == 2) begin po = 2; en = 1; sub = 1; amt = opd; end
    else if (code == 3) begin po = 4; en = 1; amt = opd; end
    else if (code == 4) begin po = 8; en = 1; amt = opd; end
    else if (code == 5) ill = 1;
    else if (code == 6) t = (z == 0);
    else if (code == 7) t = (z == 1);
    else if (code == 8) t = (n == v);
    else if (code == 9) t = (n != v);
    else if (code == 10) t = (z == 0) && (n == v);
    else if (code == 11) t = (z == 1) || (n != v);
    else if (code == 12) t = (c == 0);
    else if (code == 13) t = (c == 1);
    else if (code == 14) t = (c == 0) && (z == 0);
    else t = (c == 1) || (z == 1);
    npc = t ? opd : (p + 2) % 256;
    return {1'b1, t, ill, 4'(po), en, sub, 8'(amt), 8'(npc)};
  endfunction

  function automatic logic [24:0] observed();
    return {res_valid, taken, illegal, proc_op, sp_adj_en, sp_adj_sub, sp_adj_amt, next_pc};
  endfunction

  task automatic check_now();
    checks++;
    if (observed() !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", exp_tag, observed(), exp_v);
    end
  endtask

  // Check previous cycle's result, then drive the next request.
  task automatic step(bit vld, int code, int opd, int p, bit z, bit n, bit v, bit c);
    @(negedge clk);
    check_now();
    req_valid = vld; jcode = 4'(code); operand = 8'(opd); pc = 8'(p);
    flag_z = z; flag_n = n; flag_v = v; flag_c = c;
    if (vld) begin
      exp_v = model(code, opd, p, z, n, v, c);
      exp_tag = tag_of(code);
    end else begin
      exp_v[24] = 1'b0;   // R2: result strobe drops, other fields hold
      exp_tag = "R2";
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    exp_v = '0; exp_tag = "R1";   // R1: reset state checked at first step
    // Exhaustive sweep of codes and flags, pc at wrap point and mid-range (R8)
    for (int code = 0; code < 16; code++)
      for (int f = 0; f < 16; f++) begin
        step(1, code, 8'h40 + f, 8'hFE, f[0], f[1], f[2], f[3]);
        step(1, code, 8'hC3, 8'h11 + f, f[3], f[2], f[1], f[0]);
      end
    // Idle cycles: outputs hold (R2)
    step(1, 2, 8'h2A, 8'h10, 0, 0, 0, 0);
    step(0, 5, 8'h99, 8'h77, 1, 1, 1, 1);
    step(0, 0, 8'h01, 8'h02, 0, 0, 0, 0);
    // Pseudo-random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom;
      step((r % 5) != 0, (r >> 3) & 15, (r >> 7) & 255, (r >> 15) & 255,
           r[23], r[24], r[25], r[26]);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_now();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule